// File: doc/BRIEF.md
# Pulse-Skip Cycle Gate

This block sits between a fixed-rate oscillator tick and the logic that turns the power switch on. For every tick it decides whether a conduction period may start. It has two jobs. At startup it stops inductor current from running away. At light load it lowers the effective switching rate.

A small up/down skip depth carries the runaway guard. When a conduction period ends with the peak-current limit already reached inside the minimum on-time, the depth goes up by one and the next eligible tick is dropped. When a period ends without that early hit, the depth goes down by one, which restores one switching cycle in the pattern. A phase accumulator turns the depth into a skip pattern. At full depth, exactly every other tick is dropped, so the rate never falls below half of nominal.

A separate light-load input blocks every tick while it is high. This lets an outside comparator on the error-amplifier output thin out pulses as far as the load demands. A restart input returns the block to full rate. Soft-start re-entry drives this input.

Top module: `pskip_gate`

## Requirements
- R1: After reset the depth and phase are zero, and every tick with light_load low and restart low produces a grant.
- R2: ton_en is combinational and is high only in a cycle where osc_tick is high; it is low in every cycle without a tick.
- R3: While light_load is high, ton_en stays low and the phase does not advance; the skip pattern resumes unchanged when light_load falls.
- R4: A cyc_done pulse with lim_early high raises the depth by one, saturating at MAX_DEPTH, and forces the phase to 2*MAX_DEPTH-1, so the next eligible tick is skipped.
- R5: A cyc_done pulse with lim_early low lowers the depth by one, stopping at zero, and leaves the phase unchanged.
- R6: An eligible tick (osc_tick high, light_load low, restart low) is skipped exactly when phase+depth >= 2*MAX_DEPTH. After each eligible tick, skipped or not, the phase becomes (phase+depth) mod 2*MAX_DEPTH.
- R7: At depth MAX_DEPTH, eligible ticks alternate between skipped and granted, so the rate never drops below half the tick rate.
- R8: restart blocks the grant in its own cycle and clears the depth and the phase, taking priority over a cyc_done in the same cycle.
- R9: The depth changes only on a cyc_done or restart cycle; skipped ticks and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Soft-start re-entry; clears the skip state |
| osc_tick | input | 1 | One-cycle oscillator tick |
| cyc_done | input | 1 | One-cycle pulse at the end of a conduction period |
| lim_early | input | 1 | Peak limit reached within the minimum on-time; valid with cyc_done |
| light_load | input | 1 | Error-amplifier output below the light-load threshold |
| ton_en | output | 1 | Turn-on permission for the current tick |

## Verification
The assertions assume that cyc_done arrives only after a granted tick and never in the same cycle as osc_tick. They also assume lim_early is meaningful only while cyc_done is high. The stimulus follows this rule. Every conduction period is driven as a granted tick followed one cycle later by its completion pulse. A skipped tick never gets a completion pulse. Light-load and restart are changed only in cycles that carry no completion pulse, except for one restart case that deliberately lands on a completion pulse to check priority.

// File: rtl/pskip_pkg.sv
package pskip_pkg;

  // Skip decision: the accumulated phase plus depth reaches a full frame.
  function automatic logic skip_hit(input int unsigned ph, input int unsigned dp,
                                    input int unsigned maxd);
    return (ph + dp) >= (2 * maxd);
  endfunction

  // Phase after an eligible tick: sum folded into one frame.
  function automatic int unsigned phase_adv(input int unsigned ph, input int unsigned dp,
                                            input int unsigned maxd);
    int unsigned s;
    s = ph + dp;
    return (s >= 2 * maxd) ? s - 2 * maxd : s;
  endfunction

  // Depth after a completed conduction period.
  function automatic int unsigned depth_step(input int unsigned dp, input logic hit,
                                             input int unsigned maxd);
    if (hit) return (dp >= maxd) ? maxd : dp + 1;
    return (dp == 0) ? 0 : dp - 1;
  endfunction

endpackage

// File: rtl/pskip_depth.sv
module pskip_depth #(
  parameter int unsigned MAX_DEPTH = 4,
  localparam int unsigned DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          cyc_done,
  input  logic          lim_early,
  output logic [DW-1:0] depth
);
  import pskip_pkg::*;

  logic [DW-1:0] depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        depth_q <= '0;
    else if (restart)  depth_q <= '0;
    else if (cyc_done) depth_q <= DW'(depth_step(32'(depth_q), lim_early, MAX_DEPTH));
  end

  assign depth = depth_q;

  // R4 / R7: depth never passes its bound
  a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(depth_q) <= MAX_DEPTH);

  // R9: depth holds without a completion or restart
  a_r9_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_done && !restart) |=> $stable(depth_q));

  // R8: restart empties the depth
  a_r8_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (depth_q == '0));

  // R5: a clean completion never raises the depth
  a_r5_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !lim_early && !restart) |=> (depth_q <= $past(depth_q)));

endmodule

// File: rtl/pskip_phase.sv
module pskip_phase #(
  parameter int unsigned MAX_DEPTH = 4,
  localparam int unsigned DW = $clog2(MAX_DEPTH + 1),
  localparam int unsigned FRAME = 2 * MAX_DEPTH,
  localparam int unsigned PW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic          preset,
  input  logic [DW-1:0] depth,
  output logic          skip
);
  import pskip_pkg::*;

  logic [PW-1:0] phase_q;

  assign skip = skip_hit(32'(phase_q), 32'(depth), MAX_DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (preset)  phase_q <= PW'(FRAME - 1);
    else if (advance) phase_q <= PW'(phase_adv(32'(phase_q), 32'(depth), MAX_DEPTH));
  end

  // R6: phase stays inside one frame
  a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_q) < FRAME);

  // R3: phase frozen without an eligible tick or preset
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !preset && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/pskip_gate.sv
module pskip_gate #(
  parameter int unsigned MAX_DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic osc_tick,
  input  logic cyc_done,
  input  logic lim_early,
  input  logic light_load,
  output logic ton_en
);
  localparam int unsigned DW = $clog2(MAX_DEPTH + 1);

  logic [DW-1:0] depth;
  logic          eligible;
  logic          skip_now;
  logic          early_hit;

  assign eligible  = osc_tick && !light_load && !restart;
  assign early_hit = cyc_done && lim_early;

  pskip_depth #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .cyc_done(cyc_done), .lim_early(lim_early), .depth(depth)
  );

  pskip_phase #(.MAX_DEPTH(MAX_DEPTH)) u_phase (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .advance(eligible), .preset(early_hit),
    .depth(depth), .skip(skip_now)
  );

  assign ton_en = eligible && !skip_now;

  // R2: grant only with a tick
  a_r2_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    ton_en |-> osc_tick);

  // R3: light load blocks every grant
  a_r3_light_block: assert property (@(posedge clk) disable iff (!rst_n)
    light_load |-> !ton_en);

  // R4: after an early hit the next eligible tick is dropped
  a_r4_next_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (early_hit && !restart) |=> (eligible |-> !ton_en));

  // R8: restart blocks its own cycle
  a_r8_restart_block: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !ton_en);

endmodule

// File: tb/tb_pskip_gate.sv
module tb_pskip_gate;
  localparam int unsigned MAXD = 4;

  logic clk = 0, rst_n = 0;
  logic restart = 0, osc_tick = 0, cyc_done = 0, lim_early = 0, light_load = 0;
  logic ton_en;

  int checks = 0, errors = 0, cyc = 0;
  bit exp_q[$];
  string tag_q[$];

  int md = 0, mph = 0;  // bench model: depth, phase

  always #5 clk = ~clk;

  pskip_gate #(.MAX_DEPTH(MAXD)) dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .osc_tick(osc_tick),
    .cyc_done(cyc_done), .lim_early(lim_early), .light_load(light_load), .ton_en(ton_en)
  );

  // monitor: compare away from the edge
  always @(negedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (ton_en !== e) begin
        errors++;
        $display("FAIL %s: ton_en actual %0b expected %0b at cycle %0d", t, ton_en, e, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver: one cycle of stimulus, expected grant pushed and model advanced
  task automatic step(input bit tk, input bit dn, input bit lm, input bit ll, input bit rs,
                      input string tag, output bit g);
    bit elig, sk;
    @(negedge clk);
    osc_tick = tk; cyc_done = dn; lim_early = lm; light_load = ll; restart = rs;
    elig = tk && !ll && !rs;
    sk = (mph + md) >= 2 * MAXD;
    g = elig && !sk;
    exp_q.push_back(g);
    tag_q.push_back(tag);
    if (rs) begin
      md = 0; mph = 0;
    end else begin
      if (dn && lm) mph = 2 * MAXD - 1;
      else if (elig) mph = (mph + md) % (2 * MAXD);
      if (dn) md = lm ? ((md >= MAXD) ? MAXD : md + 1) : ((md == 0) ? 0 : md - 1);
    end
  endtask

  task automatic conduct(input bit lm, input string tag);
    bit g, x;
    step(1, 0, 0, 0, 0, tag, g);
    if (g) step(0, 1, lm, 0, 0, tag, x);
    step(0, 0, 0, 0, 0, "R2", x);
  endtask

  initial begin
    bit x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: full rate after reset
    for (int i = 0; i < 4; i++) conduct(0, "R1");
    // R2: idle cycles give no grant
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R2", x);
    // R4 then R6: one early hit, next tick dropped, then sparse pattern
    conduct(1, "R4");
    step(1, 0, 0, 0, 0, "R4", x);
    for (int i = 0; i < 10; i++) conduct(0, "R6");
    // R9: idle and skipped ticks keep depth; pattern continues
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R9", x);
    // ramp to saturation
    for (int i = 0; i < 12; i++) conduct(1, "R4");
    // R7: alternation at full depth, plain ticks
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, "R7", x);
    // R3: light load blocks and freezes phase
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, "R3", x);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R3", x);
    // R5: clean completions wind depth down
    for (int i = 0; i < 14; i++) conduct(0, "R5");
    // R8: restart blocks its tick and clears state
    for (int i = 0; i < 3; i++) conduct(1, "R8");
    step(1, 0, 0, 0, 1, "R8", x);
    for (int i = 0; i < 3; i++) conduct(0, "R8");
    // R8: restart wins over a completion in the same cycle
    conduct(1, "R8");
    step(0, 1, 1, 0, 1, "R8", x);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R8", x);
    step(0, 0, 0, 0, 0, "R2", x);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule